// File: doc/BRIEF.md
# Sectored Wait-State External SRAM Bridge

This block connects an 8-bit processor data port to an asynchronous external SRAM over a shared low-byte address/data bus. A processor request that targets the external range starts a bus cycle. The bridge first presents the full address together with a latch pulse. It then either drives write data or releases the shared lines, and holds an active-low write or read strobe for a length set by the wait-state field.

One 8-bit control register configures the bridge. It holds an enable, a 3-bit boundary code that splits the 64 KB space at an 8 KB multiple, and a separate 2-bit wait-state setting for the part above that boundary and for the part below it. While the bridge is enabled, or while a cycle is still finishing, it owns the bus pins. Otherwise the pins carry the general-purpose output and direction values supplied from outside.

Top module: `xmem_bridge`

## Requirements
- R1: The control register resets to 0x00. A write through `cfg_we` appears on `cfg_rdata` from the next cycle. The layout is: bit 7 enable, bits 6..4 boundary code, bits 3..2 upper wait setting, bits 1..0 lower wait setting.
- R2: With boundary code 000, every external address uses the upper wait setting (bits 3..2).
- R3: With boundary code k (1..7), an address whose top three bits are k or more uses bits 3..2. A lower external address uses bits 1..0.
- R4: A wait setting of 00, 01, 10 or 11 gives a strobe of 1, 2, 3 or 3 cycles. Setting 11 adds one more cycle after the strobe, in which the address is held and both strobes are high.
- R5: The cycle after a request is accepted, the latch strobe (`pin_ctl_out[2]`) is high for exactly one cycle. In that cycle `pin_ad_out` carries address bits 7..0, `pin_ahi_out` carries bits 15..8, and `pin_ad_oe` is 0xFF.
- R6: During a write strobe, `pin_ctl_out[1]` is low, `pin_ctl_out[0]` is high, and the shared lines drive the write data with `pin_ad_oe` at 0xFF. They stay driven during the hold cycle.
- R7: During a read strobe, `pin_ctl_out[0]` is low and `pin_ad_oe` is 0x00. The data is sampled at the end of the last strobe cycle. It is returned on `rd_data` with a one-cycle `rd_valid` pulse in the following cycle.
- R8: `busy` is high from the cycle after acceptance until the cycle completes. A request made while `busy` is high is ignored and never starts a bus cycle.
- R9: When the enable bit is 0, or the address is below `XSTART`, a request starts no bus cycle and `busy` stays low.
- R10: When the enable bit is 1 or `busy` is high, the bridge drives the pins. `pin_ahi_oe` is 0xFF and `pin_ctl_oe` is 111. When idle, the strobes are high (`pin_ctl_out` = 011) and `pin_ad_oe` is 0x00. Otherwise each pin output and enable equals its `gp_*` input.
- R11: The register value sampled in the acceptance cycle governs the whole access. A write in that cycle or later affects only the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register read value |
| req_valid | input | 1 | Processor access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Bus cycle in progress |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read data |
| pin_ad_in | input | 8 | Value on shared address/data lines |
| pin_ad_out | output | 8 | Output value of shared lines |
| pin_ad_oe | output | 8 | Output enable of shared lines |
| pin_ahi_out | output | 8 | Output value of high address lines |
| pin_ahi_oe | output | 8 | Output enable of high address lines |
| pin_ctl_out | output | 3 | Control pin values: [2] latch, [1] write_n, [0] read_n |
| pin_ctl_oe | output | 3 | Control pin output enables |
| gp_ad_out | input | 8 | Normal output value for shared lines |
| gp_ad_oe | input | 8 | Normal direction for shared lines |
| gp_ahi_out | input | 8 | Normal output value for high address lines |
| gp_ahi_oe | input | 8 | Normal direction for high address lines |
| gp_ctl_out | input | 3 | Normal output value for control pins |
| gp_ctl_oe | input | 3 | Normal direction for control pins |

## Verification
A register write can land in the same cycle in which a request is accepted. It can also land while that access is still in its latch or strobe phase. Both cases are provoked by raising `cfg_we` together with `req_valid`, and again on the latch cycle, each time with a different upper wait setting. The bench then counts the strobe and hold cycles of that access and of the one after it. The current access must show the old setting and the next one the new setting. Separately, a request is raised during a running cycle. The bench then checks that no second latch pulse follows.

// File: rtl/xb_pkg.sv
// Shared types and helpers of the sectored external SRAM bridge.
// Assumes an 8-bit control register with the enable bit on top.
package xb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ALE,
        ST_STB,
        ST_HOLD
    } seq_st_t;

    typedef struct packed {
        logic       en;
        logic [2:0] lim;
        logic [1:0] ws_hi;
        logic [1:0] ws_lo;
    } xcfg_t;

    // Extra strobe cycles for a wait setting.
    function automatic logic [1:0] strobe_extra(input logic [1:0] ws);
        case (ws)
            2'b00:   strobe_extra = 2'd0;
            2'b01:   strobe_extra = 2'd1;
            default: strobe_extra = 2'd2;
        endcase
    endfunction

    // Whether a wait setting adds an address-hold cycle after the strobe.
    function automatic logic wants_hold(input logic [1:0] ws);
        wants_hold = (ws == 2'b11);
    endfunction

endpackage

// File: rtl/xb_cfg_reg.sv
// Control register of the bridge: enable, boundary code, two wait settings.
// Assumes one write port; all bits reset to zero; read is the stored value.
module xb_cfg_reg
    import xb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [7:0]  wdata,
    output xcfg_t       cfg
);

    // Store the register; a write lands at the next edge.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg <= '0;
        else if (we) cfg <= xcfg_t'(wdata);
    end

    p_cfg_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(cfg));

    p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (cfg == xcfg_t'($past(wdata))));

endmodule

// File: rtl/xb_sector_decode.sv
// Picks the wait setting of an address from the boundary code.
// Assumes the address space divides into eight equal parts; code 0 = one sector.
module xb_sector_decode #(
    parameter int SEG_W = 3
) (
    input  logic [SEG_W-1:0] lim,
    input  logic [SEG_W-1:0] seg,
    input  logic [1:0]       ws_hi,
    input  logic [1:0]       ws_lo,
    output logic             upper,
    output logic [1:0]       ws_sel
);

    // Upper when no split is set or the address segment reaches the boundary.
    always_comb begin
        upper  = (lim == '0) ? 1'b1 : (seg >= lim);
        ws_sel = upper ? ws_hi : ws_lo;
    end

endmodule

// File: rtl/xb_bus_seq.sv
// Bus cycle sequencer: latch phase, strobe of 1+N cycles, optional hold.
// Assumes requests are taken only when idle; wait setting is sampled at accept.
module xb_bus_seq
    import xb_pkg::*;
#(
    parameter int              ADDR_W = 16,
    parameter int              DATA_W = 8,
    parameter logic [ADDR_W-1:0] XSTART = 16'h1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        ws,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ale,
    output logic              wr_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] ad_drv,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] ahi_drv
);

    seq_st_t           st;
    logic [1:0]        cnt;
    logic              hold_q;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic              accept;

    // A request starts a cycle only when idle, enabled and external.
    always_comb accept = req_valid && (st == ST_IDLE) && en && (req_addr >= XSTART);

    // Advance the cycle state and capture the request and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            hold_q   <= 1'b0;
            wr_q     <= 1'b0;
            addr_q   <= '0;
            wdat_q   <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (st)
                ST_IDLE: if (accept) begin
                    st     <= ST_ALE;
                    cnt    <= strobe_extra(ws);
                    hold_q <= wants_hold(ws);
                    wr_q   <= req_write;
                    addr_q <= req_addr;
                    wdat_q <= req_wdata;
                end
                ST_ALE: st <= ST_STB;
                ST_STB: begin
                    if (cnt == 2'd0) begin
                        if (!wr_q) begin
                            rd_data  <= ad_in;
                            rd_valid <= 1'b1;
                        end
                        st <= hold_q ? ST_HOLD : ST_IDLE;
                    end else begin
                        cnt <= cnt - 2'd1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Drive the bus from the current phase.
    always_comb begin
        busy    = (st != ST_IDLE);
        ale     = (st == ST_ALE);
        wr_n    = !((st == ST_STB) && wr_q);
        rd_n    = !((st == ST_STB) && !wr_q);
        ad_drv  = (st == ST_ALE) ? addr_q[DATA_W-1:0] : wdat_q;
        ad_oe   = (st == ST_ALE) || (((st == ST_STB) || (st == ST_HOLD)) && wr_q);
        ahi_drv = addr_q[ADDR_W-1:DATA_W];
    end

    p_ale_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ale);

    p_ale_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !rd_n));

    p_no_take_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

    p_off_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !en && !busy) |=> !ale);

    p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_read_follows_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!rd_n));

endmodule

// File: rtl/xb_pin_mux.sv
// Pin ownership: the bridge overrides the normal pin values when it owns the bus.
// Assumes a single owner signal; the normal values come from outside.
module xb_pin_mux #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own,
    input  logic              ale,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic [DATA_W-1:0] ad_drv,
    input  logic              ad_oe,
    input  logic [HI_W-1:0]   ahi_drv,
    input  logic [DATA_W-1:0] gp_ad_out,
    input  logic [DATA_W-1:0] gp_ad_oe,
    input  logic [HI_W-1:0]   gp_ahi_out,
    input  logic [HI_W-1:0]   gp_ahi_oe,
    input  logic [2:0]        gp_ctl_out,
    input  logic [2:0]        gp_ctl_oe,
    output logic [DATA_W-1:0] pin_ad_out,
    output logic [DATA_W-1:0] pin_ad_oe,
    output logic [HI_W-1:0]   pin_ahi_out,
    output logic [HI_W-1:0]   pin_ahi_oe,
    output logic [2:0]        pin_ctl_out,
    output logic [2:0]        pin_ctl_oe
);

    // Select bridge or normal values for every pin group.
    always_comb begin
        if (own) begin
            pin_ad_out  = ad_drv;
            pin_ad_oe   = {DATA_W{ad_oe}};
            pin_ahi_out = ahi_drv;
            pin_ahi_oe  = '1;
            pin_ctl_out = {ale, wr_n, rd_n};
            pin_ctl_oe  = 3'b111;
        end else begin
            pin_ad_out  = gp_ad_out;
            pin_ad_oe   = gp_ad_oe;
            pin_ahi_out = gp_ahi_out;
            pin_ahi_oe  = gp_ahi_oe;
            pin_ctl_out = gp_ctl_out;
            pin_ctl_oe  = gp_ctl_oe;
        end
    end

    p_strobe_owned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n || !rd_n || ale) |-> (pin_ctl_oe == 3'b111));

endmodule

// File: rtl/xmem_bridge.sv
// Top of the sectored wait-state external SRAM bridge.
// Assumes a 16-bit address, 8-bit data, external space starting at XSTART.
module xmem_bridge
    import xb_pkg::*;
#(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 8,
    parameter logic [ADDR_W-1:0] XSTART = 16'h1100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] pin_ad_in,
    output logic [DATA_W-1:0] pin_ad_out,
    output logic [DATA_W-1:0] pin_ad_oe,
    output logic [ADDR_W-DATA_W-1:0] pin_ahi_out,
    output logic [ADDR_W-DATA_W-1:0] pin_ahi_oe,
    output logic [2:0]        pin_ctl_out,
    output logic [2:0]        pin_ctl_oe,
    input  logic [DATA_W-1:0] gp_ad_out,
    input  logic [DATA_W-1:0] gp_ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] gp_ahi_out,
    input  logic [ADDR_W-DATA_W-1:0] gp_ahi_oe,
    input  logic [2:0]        gp_ctl_out,
    input  logic [2:0]        gp_ctl_oe
);

    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int SEG_W = 3;

    xcfg_t             cfg;
    logic              upper;
    logic [1:0]        ws_sel;
    logic              ale, wr_n, rd_n, ad_oe;
    logic [DATA_W-1:0] ad_drv;
    logic [HI_W-1:0]   ahi_drv;

    // Register read-back.
    always_comb cfg_rdata = cfg;

    xb_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    xb_sector_decode #(.SEG_W(SEG_W)) u_dec (
        .lim    (cfg.lim),
        .seg    (req_addr[ADDR_W-1 -: SEG_W]),
        .ws_hi  (cfg.ws_hi),
        .ws_lo  (cfg.ws_lo),
        .upper  (upper),
        .ws_sel (ws_sel)
    );

    xb_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .XSTART(XSTART)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg.en),
        .ws        (ws_sel),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ad_in     (pin_ad_in),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ale       (ale),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .ad_drv    (ad_drv),
        .ad_oe     (ad_oe),
        .ahi_drv   (ahi_drv)
    );

    xb_pin_mux #(.DATA_W(DATA_W), .HI_W(HI_W)) u_mux (
        .clk         (clk),
        .rst_n       (rst_n),
        .own         (cfg.en || busy),
        .ale         (ale),
        .wr_n        (wr_n),
        .rd_n        (rd_n),
        .ad_drv      (ad_drv),
        .ad_oe       (ad_oe),
        .ahi_drv     (ahi_drv),
        .gp_ad_out   (gp_ad_out),
        .gp_ad_oe    (gp_ad_oe),
        .gp_ahi_out  (gp_ahi_out),
        .gp_ahi_oe   (gp_ahi_oe),
        .gp_ctl_out  (gp_ctl_out),
        .gp_ctl_oe   (gp_ctl_oe),
        .pin_ad_out  (pin_ad_out),
        .pin_ad_oe   (pin_ad_oe),
        .pin_ahi_out (pin_ahi_out),
        .pin_ahi_oe  (pin_ahi_oe),
        .pin_ctl_out (pin_ctl_out),
        .pin_ctl_oe  (pin_ctl_oe)
    );

    p_split_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.lim != 3'd0 && req_addr[ADDR_W-1 -: SEG_W] < cfg.lim) |-> !upper);

endmodule

// File: tb/xmem_bridge_tb.sv
// Directed bench for the sectored external SRAM bridge.
module xmem_bridge_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rd_valid;
    logic [7:0]  rd_data;
    logic [7:0]  pin_ad_in;
    logic [7:0]  pin_ad_out, pin_ad_oe, pin_ahi_out, pin_ahi_oe;
    logic [2:0]  pin_ctl_out, pin_ctl_oe;
    logic [7:0]  gp_ad_out  = 8'h3C;
    logic [7:0]  gp_ad_oe   = 8'h0F;
    logic [7:0]  gp_ahi_out = 8'hC3;
    logic [7:0]  gp_ahi_oe  = 8'hF0;
    logic [2:0]  gp_ctl_out = 3'b101;
    logic [2:0]  gp_ctl_oe  = 3'b010;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [15:0] lat_addr = '0;
    logic [1:0]  stbcnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .pin_ad_in(pin_ad_in), .pin_ad_out(pin_ad_out), .pin_ad_oe(pin_ad_oe),
        .pin_ahi_out(pin_ahi_out), .pin_ahi_oe(pin_ahi_oe),
        .pin_ctl_out(pin_ctl_out), .pin_ctl_oe(pin_ctl_oe),
        .gp_ad_out(gp_ad_out), .gp_ad_oe(gp_ad_oe), .gp_ahi_out(gp_ahi_out),
        .gp_ahi_oe(gp_ahi_oe), .gp_ctl_out(gp_ctl_out), .gp_ctl_oe(gp_ctl_oe)
    );

    // Memory model: value depends on latched address and strobe cycle index.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always @(negedge clk) if (pin_ctl_out[2] && pin_ctl_oe[2]) lat_addr <= {pin_ahi_out, pin_ad_out};
    always @(posedge clk) stbcnt <= (!rst_n || pin_ctl_out[0]) ? 2'd0 : stbcnt + 2'd1;
    assign pin_ad_in = mem_byte(lat_addr) ^ {6'b0, stbcnt};

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wcfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Run one access and measure its phases; checks R5..R8 and the given tag.
    task automatic run_acc(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                           input logic use_acc, input logic [7:0] poke_acc,
                           input logic use_mid, input logic [7:0] poke_mid,
                           input logic mid_req, input int exp_stb, input int exp_hold,
                           input string tag);
        int stb = 0, hold = 0, rdv = 0, iter = 0;
        bit addr_ok = 1'b1, wdat_ok = 1'b1, rel_ok = 1'b1;
        logic [7:0] got = '0;
        logic [7:0] exp_rd;
        exp_rd = mem_byte(a) ^ 8'(exp_stb - 1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        if (use_acc) begin cfg_we = 1'b1; cfg_wdata = poke_acc; end
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        chk(pin_ctl_out[2] === 1'b1, "R5", "latch in first cycle", pin_ctl_out[2], 1);
        chk(busy === 1'b1, "R8", "busy after accept", busy, 1);
        if (use_mid) begin cfg_we = 1'b1; cfg_wdata = poke_mid; end
        if (mid_req) begin req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h9000; end
        while (iter < 20) begin
            if (pin_ctl_out[2]) begin
                if (pin_ahi_out !== a[15:8] || pin_ad_out !== a[7:0] || pin_ad_oe !== 8'hFF) addr_ok = 1'b0;
            end else if (!pin_ctl_out[1] || !pin_ctl_out[0]) begin
                stb++;
                if (wr && (pin_ad_out !== wd || pin_ad_oe !== 8'hFF || pin_ctl_out[0] !== 1'b1)) wdat_ok = 1'b0;
                if (!wr && (pin_ad_oe !== 8'h00 || pin_ctl_out[1] !== 1'b1)) rel_ok = 1'b0;
            end else if (busy) begin
                hold++;
                if (pin_ahi_out !== a[15:8]) addr_ok = 1'b0;
                if (wr && (pin_ad_out !== wd || pin_ad_oe !== 8'hFF)) wdat_ok = 1'b0;
            end
            if (rd_valid) begin rdv++; got = rd_data; end
            if (!busy) break;
            @(negedge clk);
            cfg_we = 1'b0; req_valid = 1'b0;
            iter++;
        end
        chk(iter < 20, "R8", "busy released", iter, 20);
        chk(addr_ok, "R5", "address phase", addr_ok, 1);
        chk(stb == exp_stb, tag, "strobe cycles", stb, exp_stb);
        chk(hold == exp_hold, tag, "hold cycles", hold, exp_hold);
        if (wr) begin
            chk(wdat_ok, "R6", "write data on bus", wdat_ok, 1);
            chk(rdv == 0, "R6", "no read pulse on write", rdv, 0);
        end else begin
            chk(rel_ok, "R7", "lines released on read", rel_ok, 1);
            chk(rdv == 1, "R7", "one read pulse", rdv, 1);
            chk(got == exp_rd, "R7", "read data last strobe", got, exp_rd);
        end
        if (mid_req) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                chk(pin_ctl_out[2] == 1'b0 && !busy, "R8", "request while busy ignored", pin_ctl_out[2], 0);
            end
        end
    endtask

    task automatic no_cycle(input logic [15:0] a, input string tag);
        bit seen = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (busy || (pin_ctl_out[2] && pin_ctl_oe[2])) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, tag, "no bus cycle", seen, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(cfg_rdata == 8'h00, "R1", "register reset", cfg_rdata, 0);
        chk(busy == 1'b0 && rd_valid == 1'b0, "R8", "idle after reset", busy, 0);
        chk(pin_ad_out == gp_ad_out && pin_ad_oe == gp_ad_oe && pin_ahi_out == gp_ahi_out
            && pin_ahi_oe == gp_ahi_oe && pin_ctl_out == gp_ctl_out && pin_ctl_oe == gp_ctl_oe,
            "R10", "normal pins when off", pin_ctl_oe, gp_ctl_oe);
    endtask

    task automatic t_regrw;
        wcfg(8'h5A);
        chk(cfg_rdata == 8'h5A, "R1", "read back", cfg_rdata, 8'h5A);
        wcfg(8'h07);
        chk(cfg_rdata == 8'h07, "R1", "read back", cfg_rdata, 8'h07);
    endtask

    task automatic t_off;
        no_cycle(16'h8000, "R9");
        chk(pin_ahi_oe == gp_ahi_oe && pin_ad_out == gp_ad_out, "R10", "pins normal when off", pin_ahi_oe, gp_ahi_oe);
    endtask

    task automatic t_single;
        wcfg(8'h87);
        chk(pin_ahi_oe == 8'hFF && pin_ctl_oe == 3'b111 && pin_ctl_out == 3'b011 && pin_ad_oe == 8'h00,
            "R10", "idle override", pin_ctl_out, 3'b011);
        no_cycle(16'h10FF, "R9");
        run_acc(1'b1, 16'h1200, 8'hA7, 0, 0, 0, 0, 0, 2, 0, "R2");
        run_acc(1'b0, 16'hF0F0, 8'h00, 0, 0, 0, 0, 0, 2, 0, "R2");
    endtask

    task automatic t_split;
        wcfg(8'hB2);
        run_acc(1'b0, 16'h5FFF, 8'h00, 0, 0, 0, 0, 0, 3, 0, "R3");
        run_acc(1'b0, 16'h6000, 8'h00, 0, 0, 0, 0, 0, 1, 0, "R3");
        run_acc(1'b1, 16'hE123, 8'h4D, 0, 0, 0, 0, 0, 1, 0, "R3");
    endtask

    task automatic t_hold;
        wcfg(8'hFB);
        run_acc(1'b1, 16'h3456, 8'h99, 0, 0, 0, 0, 0, 3, 1, "R4");
        run_acc(1'b0, 16'h2345, 8'h00, 0, 0, 0, 0, 0, 3, 1, "R4");
        run_acc(1'b0, 16'hE000, 8'h00, 0, 0, 0, 0, 0, 3, 0, "R4");
    endtask

    task automatic t_live;
        wcfg(8'h90);
        run_acc(1'b0, 16'h4000, 8'h00, 1, 8'h98, 0, 0, 0, 1, 0, "R11");
        run_acc(1'b1, 16'h4001, 8'h11, 0, 0, 1, 8'h9C, 1, 3, 0, "R11");
        run_acc(1'b0, 16'h4002, 8'h00, 0, 0, 0, 0, 0, 3, 1, "R11");
        chk(cfg_rdata == 8'h9C, "R11", "late write kept", cfg_rdata, 8'h9C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_regrw;
        t_off;
        t_single;
        t_split;
        t_hold;
        t_live;
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule